// File: doc/BRIEF.md
# Sleep Entry and Wake Sequencer

This block steps a processor system into a hardware power-down state and back out again. When firmware sets the sleep bit, the block raises a bus request toward the CPU at once. It then waits for the CPU to acknowledge at an instruction boundary. On the falling CPU-clock edge that follows the acknowledge, it asserts the system-wide power-down line. The flash, the CPU and the interrupt controller stay outside the block, which models only its handshakes with them.

Any pending interrupt that is not masked brings the system out of power-down. The global interrupt enable plays no part: the block has no input for it. The wake request reaches the slow-clock side through a two-stage synchronizer, and power-down drops on a slow-clock edge. The clock select is forced to the internal oscillator while a fixed number of slow-clock periods elapse for recovery. After that the bus request is released, a ready pulse is issued, and a one-cycle request to clear the sleep bit goes out.

A watchdog reset or a power-on reset ends the sequence at any point. A sleep attempt is abandoned without power-down if the sleep bit is cleared, or a wake arrives, before power-down has been asserted.

Top module: `sleep_seq`

## Requirements
- R1: While reset is active and directly after it is released, `bus_req`, `pwr_dn`, `clk_sel_int`, `cpu_ready` and `sleep_clr` are all 0.
- R2: With no unmasked interrupt pending, setting `sleep_bit` raises `bus_req` in the same clock cycle, before the next rising edge of `clk_cpu`.
- R3: `pwr_dn` stays 0 until `cpu_ack` has been sampled high on a rising edge of `clk_cpu`. It then rises on the falling edge of `clk_cpu` directly after that rising edge.
- R4: During power-down, a pending bit whose mask bit is 0 does not end power-down. A pending bit whose mask bit is 1 ends it (mask value 1 means enabled).
- R5: `pwr_dn` falls only on the first slow-clock tick that sees the synchronized wake. `bus_req` stays 1 when `pwr_dn` falls.
- R6: `cpu_ready` rises after exactly REC_TICKS rising edges of `clk_slow` (default 3) following the fall of `pwr_dn`. `bus_req` stays 1 until then and is 0 while `cpu_ready` is 1.
- R7: `sleep_clr` is 1 in the cycle `cpu_ready` is 1 and is a single-cycle pulse.
- R8: If `sleep_bit` is cleared before power-down is asserted, the attempt is abandoned: `bus_req` returns to 0 and `pwr_dn` never rises. This holds even when the clear is sampled on the same edge as `cpu_ack`.
- R9: An unmasked pending interrupt that appears while the bus request is outstanding, before power-down, abandons the attempt without raising `pwr_dn`.
- R10: A `wdt_rst` pulse during power-down drops `pwr_dn` and `bus_req` on the next rising edge of `clk_cpu`, and no `cpu_ready` follows.
- R11: Driving `rst_n` low during power-down drops `pwr_dn` and `bus_req` without waiting for a clock edge.
- R12: `clk_sel_int` is 1 from the fall of `pwr_dn` through the `cpu_ready` cycle, and 0 during power-down and in normal running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU clock |
| clk_slow | input | 1 | Free-running slow clock, sampled as data |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sleep_bit | input | 1 | Sleep request bit from the status register |
| cpu_ack | input | 1 | Bus-request acknowledge from the CPU |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| irq_mask | input | N_IRQ | Interrupt mask, 1 = enabled for wake |
| wdt_rst | input | 1 | Watchdog reset pulse, synchronous to clk_cpu |
| bus_req | output | 1 | Bus request to the CPU |
| pwr_dn | output | 1 | System-wide power-down |
| clk_sel_int | output | 1 | Forces the CPU clock select to the internal oscillator |
| cpu_ready | output | 1 | One-cycle pulse when recovery has finished |
| sleep_clr | output | 1 | One-cycle request to clear the sleep bit |

## Verification
The acknowledge from the CPU and the withdrawal of the sleep bit can reach the sequencer on the same rising edge while the request is still outstanding. Withdrawal must win. The bench provokes this by raising `cpu_ack` and clearing `sleep_bit` in one drive. It then requires that `bus_req` returns to 0 and that `pwr_dn` stays low for several cycles. A second overlap is between the watchdog pulse and a sequencer parked in power-down. There the bench judges that the return to running is clean and that no ready pulse follows.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_REQ    = 3'd1,
    ST_WAITN  = 3'd2,
    ST_PD     = 3'd3,
    ST_RECOV  = 3'd4,
    ST_RESUME = 3'd5
  } seq_state_e;

endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/ss_tick_sync.sv
module ss_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_in,
  output logic tick
);

  localparam int unsigned W = STAGES + 1;

  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[W-2:0], slow_in};
  end

  assign tick = sh_q[W-2] & ~sh_q[W-1];

endmodule

// File: rtl/ss_wake_sync.sv
module ss_wake_sync #(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             tick,
  input  logic             clr,
  output logic             wake_q,
  output logic             wake_slow
);

  logic wake_d;
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  assign wake_d = |(irq_pend & irq_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  always_comb begin
    s1_d = s1_q;
    s2_d = s2_q;
    if (clr) begin
      s1_d = 1'b0;
      s2_d = 1'b0;
    end else if (tick) begin
      s1_d = wake_q;
      s2_d = s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign wake_slow = s2_q;

  p_wake_needs_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s2_q) |-> $past(s1_q));

endmodule

// File: rtl/ss_rec_cnt.sv
module ss_rec_cnt #(
  parameter int unsigned REC_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic done
);

  localparam int unsigned CW = (REC_TICKS < 2) ? 1 : $clog2(REC_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(REC_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                    cnt_d = '0;
    else if (tick && !done)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = !clr && tick && (cnt_q == LAST);

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_pkg::*;
#(
  parameter int unsigned N_IRQ     = 8,
  parameter int unsigned REC_TICKS = 3
) (
  input  logic             clk_cpu,
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             sleep_bit,
  input  logic             cpu_ack,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             wdt_rst,
  output logic             bus_req,
  output logic             pwr_dn,
  output logic             clk_sel_int,
  output logic             cpu_ready,
  output logic             sleep_clr
);

  seq_state_e state_q, state_d;
  logic rst_s;
  logic slow_tick;
  logic wake_q, wake_slow;
  logic rec_done;
  logic pd_neg_q, pd_neg_d;
  logic abort;
  logic in_pd_span;

  ss_rst_sync u_rst (
    .clk        (clk_cpu),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  ss_tick_sync #(.STAGES(2)) u_tick (
    .clk     (clk_cpu),
    .rst_n   (rst_s),
    .slow_in (clk_slow),
    .tick    (slow_tick)
  );

  ss_wake_sync #(.N_IRQ(N_IRQ)) u_wake (
    .clk       (clk_cpu),
    .rst_n     (rst_s),
    .irq_pend  (irq_pend),
    .irq_mask  (irq_mask),
    .tick      (slow_tick),
    .clr       (state_q == ST_RUN),
    .wake_q    (wake_q),
    .wake_slow (wake_slow)
  );

  ss_rec_cnt #(.REC_TICKS(REC_TICKS)) u_rec (
    .clk   (clk_cpu),
    .rst_n (rst_s),
    .clr   (state_q != ST_RECOV),
    .tick  (slow_tick),
    .done  (rec_done)
  );

  assign abort = !sleep_bit || wake_q;

  always_comb begin
    state_d = state_q;
    if (wdt_rst) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN:    if (sleep_bit && !wake_q) state_d = ST_REQ;
        ST_REQ:    if (abort)                state_d = ST_RUN;
                   else if (cpu_ack)         state_d = ST_WAITN;
        ST_WAITN:  if (pd_neg_q)             state_d = ST_PD;
                   else if (abort)           state_d = ST_RUN;
        ST_PD:     if (slow_tick && wake_slow) state_d = ST_RECOV;
        ST_RECOV:  if (rec_done)             state_d = ST_RESUME;
        ST_RESUME:                           state_d = ST_RUN;
        default:                             state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_cpu or negedge rst_s) begin
    if (!rst_s) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  // power-down launches on the falling edge after the acknowledged rising edge
  always_comb begin
    pd_neg_d = 1'b0;
    if (state_q == ST_WAITN) pd_neg_d = sleep_bit && !wake_q && !wdt_rst;
    else if (state_q == ST_PD) pd_neg_d = 1'b1;
  end

  always_ff @(negedge clk_cpu or negedge rst_s) begin
    if (!rst_s) pd_neg_q <= 1'b0;
    else        pd_neg_q <= pd_neg_d;
  end

  assign in_pd_span  = (state_q == ST_WAITN) || (state_q == ST_PD);
  assign pwr_dn      = rst_s && pd_neg_q && in_pd_span;
  assign bus_req     = rst_s && (((state_q == ST_RUN) && sleep_bit && !wake_q && !wdt_rst)
                                 || (state_q == ST_REQ) || in_pd_span
                                 || (state_q == ST_RECOV));
  assign clk_sel_int = rst_s && ((state_q == ST_RECOV) || (state_q == ST_RESUME));
  assign cpu_ready   = rst_s && (state_q == ST_RESUME);
  assign sleep_clr   = rst_s && (state_q == ST_RESUME);

  p_pd_has_req_r3: assert property (@(posedge clk_cpu) disable iff (!rst_s)
    pwr_dn |-> bus_req);

  p_pd_fall_tick_r5: assert property (@(posedge clk_cpu) disable iff (!rst_s)
    $fell(pwr_dn) |-> ($past(slow_tick) || $past(wdt_rst)));

  p_ready_released_r6: assert property (@(posedge clk_cpu) disable iff (!rst_s)
    cpu_ready |-> (!bus_req && !pwr_dn));

  p_clr_pulse_r7: assert property (@(posedge clk_cpu) disable iff (!rst_s)
    sleep_clr |=> !sleep_clr);

  p_wdt_ends_r10: assert property (@(posedge clk_cpu) disable iff (!rst_s)
    wdt_rst |=> (!pwr_dn && !cpu_ready));

  p_sel_not_pd_r12: assert property (@(posedge clk_cpu) disable iff (!rst_s)
    clk_sel_int |-> !pwr_dn);

endmodule

// File: tb/sleep_seq_bench.sv
module sleep_seq_bench;

  localparam int unsigned N = 8;

  logic clk_cpu = 1'b0;
  logic clk_slow = 1'b0;
  logic rst_n, sleep_bit, cpu_ack, wdt_rst;
  logic [N-1:0] irq_pend, irq_mask;
  logic bus_req, pwr_dn, clk_sel_int, cpu_ready, sleep_clr;

  int n_chk = 0;
  int n_bad = 0;
  int slow_cnt = 0;
  logic slow_cnt_en = 1'b0;
  logic done = 1'b0;

  always #2 clk_cpu = ~clk_cpu;
  initial begin
    #3;
    forever #32 clk_slow = ~clk_slow;
  end

  always @(posedge clk_slow) if (slow_cnt_en) slow_cnt <= slow_cnt + 1;

  sleep_seq #(.N_IRQ(N), .REC_TICKS(3)) u_sleep_seq (
    .clk_cpu(clk_cpu), .clk_slow(clk_slow), .rst_n(rst_n),
    .sleep_bit(sleep_bit), .cpu_ack(cpu_ack), .irq_pend(irq_pend),
    .irq_mask(irq_mask), .wdt_rst(wdt_rst), .bus_req(bus_req),
    .pwr_dn(pwr_dn), .clk_sel_int(clk_sel_int), .cpu_ready(cpu_ready),
    .sleep_clr(sleep_clr)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drv();
    @(posedge clk_cpu); #1;
  endtask

  task automatic smp();
    @(negedge clk_cpu); #1;
  endtask

  task automatic enter_pd();
    drv(); sleep_bit = 1'b1; #1;
    chk(bus_req === 1'b1, "R2 bus_req same cycle", bus_req, 1);
    smp(); chk(pwr_dn === 1'b0, "R3 no pd before ack", pwr_dn, 0);
    drv(); drv(); cpu_ack = 1'b1;
    smp(); chk(pwr_dn === 1'b0, "R3 no pd before ack sampled", pwr_dn, 0);
    smp(); chk(pwr_dn === 1'b1, "R3 pd on falling edge", pwr_dn, 1);
  endtask

  task automatic wake_recover(input logic [N-1:0] pend, input logic [N-1:0] msk);
    int waited;
    drv(); irq_pend = pend; irq_mask = msk;
    waited = 0;
    do begin smp(); waited++; end while (pwr_dn && waited < 150);
    chk(pwr_dn === 1'b0, "R4 unmasked wake ends pd", pwr_dn, 0);
    chk(bus_req === 1'b1, "R5 bus_req held at pd fall", bus_req, 1);
    chk(clk_sel_int === 1'b1, "R12 clk_sel_int after pd", clk_sel_int, 1);
    slow_cnt = 0; slow_cnt_en = 1'b1;
    waited = 0;
    while (!cpu_ready && waited < 150) begin
      chk(bus_req === 1'b1, "R6 bus_req held in recovery", bus_req, 1);
      smp(); waited++;
    end
    slow_cnt_en = 1'b0;
    chk(cpu_ready === 1'b1, "R6 ready seen", cpu_ready, 1);
    chk(slow_cnt == 3, "R6 slow edges in recovery", slow_cnt, 3);
    chk(bus_req === 1'b0, "R6 bus_req released", bus_req, 0);
    chk(sleep_clr === 1'b1, "R7 sleep_clr with ready", sleep_clr, 1);
    chk(clk_sel_int === 1'b1, "R12 clk_sel_int in ready cycle", clk_sel_int, 1);
    drv(); sleep_bit = 1'b0; cpu_ack = 1'b0; irq_pend = '0;
    smp();
    chk(sleep_clr === 1'b0, "R7 sleep_clr single cycle", sleep_clr, 0);
    chk(clk_sel_int === 1'b0, "R12 clk_sel_int off in run", clk_sel_int, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sleep_bit = 1'b0; cpu_ack = 1'b0; wdt_rst = 1'b0;
    irq_pend = '0; irq_mask = '0;
    #1;
    chk({bus_req, pwr_dn, clk_sel_int, cpu_ready, sleep_clr} === 5'b0, "R1 in reset",
        {bus_req, pwr_dn, clk_sel_int, cpu_ready, sleep_clr}, 0);
    repeat (3) drv();
    rst_n = 1'b1;
    repeat (4) smp();
    chk({bus_req, pwr_dn, clk_sel_int, cpu_ready, sleep_clr} === 5'b0, "R1 after reset",
        {bus_req, pwr_dn, clk_sel_int, cpu_ready, sleep_clr}, 0);
  endtask

  task automatic t_masked_then_unmasked();
    enter_pd();
    chk(clk_sel_int === 1'b0, "R12 clk_sel_int low in pd", clk_sel_int, 0);
    drv(); irq_pend = 8'h01; irq_mask = 8'hFE;
    for (int i = 0; i < 96; i++) begin
      smp();
      if (!pwr_dn) break;
    end
    chk(pwr_dn === 1'b1, "R4 masked pending ignored", pwr_dn, 1);
    wake_recover(8'h01, 8'h01);
  endtask

  task automatic t_high_bit_wake();
    enter_pd();
    wake_recover(8'h80, 8'hC0);
  endtask

  task automatic t_abort_clear();
    int seen;
    drv(); sleep_bit = 1'b1;
    drv(); drv(); sleep_bit = 1'b0;
    @(posedge clk_cpu); smp();
    chk(bus_req === 1'b0, "R8 abort drops bus_req", bus_req, 0);
    seen = 0;
    for (int i = 0; i < 8; i++) begin smp(); if (pwr_dn) seen = 1; end
    chk(seen == 0, "R8 no pd after abort", seen, 0);
  endtask

  task automatic t_abort_coincide();
    int seen;
    drv(); sleep_bit = 1'b1;
    drv(); cpu_ack = 1'b1; sleep_bit = 1'b0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin smp(); if (pwr_dn) seen = 1; end
    chk(seen == 0, "R8 clear beats ack", seen, 0);
    chk(bus_req === 1'b0, "R8 bus_req low after coincide", bus_req, 0);
    drv(); cpu_ack = 1'b0;
  endtask

  task automatic t_abort_wake();
    int seen;
    drv(); sleep_bit = 1'b1;
    drv(); irq_pend = 8'h10; irq_mask = 8'h10;
    seen = 0;
    for (int i = 0; i < 8; i++) begin smp(); if (pwr_dn) seen = 1; end
    chk(seen == 0, "R9 wake before pd aborts", seen, 0);
    chk(bus_req === 1'b0, "R9 bus_req released", bus_req, 0);
    drv(); sleep_bit = 1'b0; irq_pend = '0;
  endtask

  task automatic t_wdt();
    int rdy;
    enter_pd();
    drv(); wdt_rst = 1'b1; sleep_bit = 1'b0;
    smp();
    chk(pwr_dn === 1'b1, "R10 pd held before edge", pwr_dn, 1);
    drv(); wdt_rst = 1'b0; cpu_ack = 1'b0;
    chk(pwr_dn === 1'b0, "R10 pd dropped by wdt", pwr_dn, 0);
    chk(bus_req === 1'b0, "R10 bus_req dropped by wdt", bus_req, 0);
    rdy = 0;
    for (int i = 0; i < 80; i++) begin smp(); if (cpu_ready) rdy = 1; end
    chk(rdy == 0, "R10 no ready after wdt", rdy, 0);
  endtask

  task automatic t_por();
    enter_pd();
    #1; rst_n = 1'b0; sleep_bit = 1'b0; cpu_ack = 1'b0;
    #0.5;
    chk(pwr_dn === 1'b0, "R11 pd dropped by por", pwr_dn, 0);
    chk(bus_req === 1'b0, "R11 bus_req dropped by por", bus_req, 0);
    repeat (2) drv();
    rst_n = 1'b1;
    repeat (4) smp();
  endtask

  initial begin
    t_reset();
    t_masked_then_unmasked();
    t_high_bit_wake();
    t_abort_clear();
    t_abort_coincide();
    t_abort_wake();
    t_wdt();
    t_por();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_cpu);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule